// File: doc/BRIEF.md
# SMBus Slave Address and Acknowledge Engine

This block is the target side of an SMBus two-wire link. It runs from a fast system clock and oversamples the clock and data lines through a short synchronizer. After a START it shifts in the address byte, most significant bit first, and compares the upper seven bits with its configured address. On a match it pulls the data line low for the acknowledge clock. The lowest bit of the address byte then selects one of two directions: the engine receives data bytes and hands them to local logic, or it fetches bytes from local logic and shifts them out.

Each byte crosses to the local side through a handshake, and the engine keeps the clock line low for as long as that handshake is open. For a received byte the local side returns its acknowledge choice together with the ready strobe. For transmission, a master NACK ends the read: the data line stays released until the next START. Optional parameters let the engine also answer the general call (address zero, write) and the alert response address (0x0C). A timeout input from outside drops the engine back to idle.

Top module: `smb_slave_engine`

## Requirements
- R1: After reset both line outputs are released and neither rx_valid_o nor tx_req_o is asserted.
- R2: An address byte whose upper seven bits equal OWN_ADDR is always acknowledged: sda_low_o is high during the high phase of the ninth clock. A byte that matches nothing is not acknowledged, and neither it nor any following byte reaches the local side until the next START.
- R3: When GCALL_ACK_EN is set, address byte 0x00 (address zero, write) is acknowledged. Address zero with the read bit set is not. match_kind_o reads 1 for own address, 2 for general call and 3 for alert response. The value holds for the whole transaction.
- R4: When ALERT_ACK_EN is set, address 0x0C is acknowledged in either direction. With both enables clear, only OWN_ADDR is acknowledged.
- R5: In write mode, after the eighth bit of each data byte the engine holds scl_low_o and presents rx_valid_o with the byte (first bit received in bit 7). Both stay stable until rx_ready_i. rx_valid_o and tx_req_o are never high together.
- R6: The acknowledge for a received data byte follows rx_ack_i sampled with rx_ready_i: 1 drives the data line low for the ninth clock, and 0 leaves it released.
- R7: In read mode, after the address acknowledge and after each master ACK, the engine raises tx_req_o and holds scl_low_o until tx_valid_i. It then shifts tx_data_i out MSB first, changing sda_low_o only while the clock line is low.
- R8: A master NACK after a transmitted byte ends the read. No further tx_req_o occurs and the data line stays released until the next START.
- R9: A START seen at any point, including in the middle of a byte, restarts address reception.
- R10: A STOP returns the engine to idle. Bytes clocked afterwards without a START are neither acknowledged nor delivered.
- R11: A cycle with timeout_i high returns the engine to idle. On the next cycle both line outputs are released and no handshake is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| timeout_i | input | 1 | External bus timeout; forces idle |
| scl_i | input | 1 | Sensed level of the bus clock line |
| sda_i | input | 1 | Sensed level of the bus data line |
| scl_low_o | output | 1 | 1 pulls the clock line low (stretch) |
| sda_low_o | output | 1 | 1 pulls the data line low |
| match_kind_o | output | 2 | Matched address kind: 0 none, 1 own, 2 general call, 3 alert response |
| rx_valid_o | output | 1 | A received data byte is waiting |
| rx_data_o | output | 8 | Received data byte |
| rx_ready_i | input | 1 | Local side takes the received byte |
| rx_ack_i | input | 1 | Acknowledge choice for that byte (1 ACK, 0 NACK) |
| tx_req_o | output | 1 | Engine wants a byte to transmit |
| tx_valid_i | input | 1 | Local side supplies tx_data_i |
| tx_data_i | input | 8 | Byte to transmit |

## Verification
The hardest situations to reach from the pins are those where the engine must drop a transaction halfway through. Examples are a START that arrives after only half an address byte, a read that continues clocking after the master's NACK, and a timeout that strikes while the engine is stretching the clock. To reach them, the bench drives an open-drain master model bit by bit, so it can abandon a byte at any point. A gated local responder can withhold its reply to keep the engine in its hold state. Separately, all 256 address byte values are swept against two instances, one with the reserved-address options on and one with them off, and every acknowledge is compared against the arithmetic expectation.

// File: rtl/smb_slv_pkg.sv
package smb_slv_pkg;
   localparam int BYTE_W = 8;
   localparam logic [6:0] GCALL_ADDR = 7'h00;
   localparam logic [6:0] ALERT_ADDR = 7'h0C;

   typedef enum logic [3:0] {
      S_IDLE, S_ADDR, S_AACK, S_RX, S_RHOLD, S_RACK,
      S_THOLD, S_TX, S_TMACK, S_SKIP
   } smb_state_e;

   localparam logic [1:0] HIT_NONE  = 2'd0;
   localparam logic [1:0] HIT_OWN   = 2'd1;
   localparam logic [1:0] HIT_GCALL = 2'd2;
   localparam logic [1:0] HIT_ALERT = 2'd3;
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic [STAGES-1:0] scl_pipe, sda_pipe;
   logic              scl_d, sda_d;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_pipe <= '1;
               sda_pipe <= '1;
            end else begin
               scl_pipe <= scl_i;
               sda_pipe <= sda_i;
            end
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_pipe <= '1;
               sda_pipe <= '1;
            end else begin
               scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
               sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_s;
         sda_d <= sda_s;
      end
   end

   assign scl_s     = scl_pipe[STAGES-1];
   assign sda_s     = sda_pipe[STAGES-1];
   assign scl_rise  = scl_s & ~scl_d;
   assign scl_fall  = ~scl_s & scl_d;
   assign start_det = scl_s & scl_d & sda_d & ~sda_s;
   assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/smb_addr_match.sv
module smb_addr_match
   import smb_slv_pkg::*;
#(
   parameter logic [6:0] OWN_ADDR     = 7'h2D,
   parameter bit         GCALL_ACK_EN = 1'b1,
   parameter bit         ALERT_ACK_EN = 1'b1
) (
   input  logic [BYTE_W-1:0] addr_byte,
   output logic [1:0]        hit
);
   logic own_hit, gcall_hit, alert_hit;

   assign own_hit = (addr_byte[7:1] == OWN_ADDR);

   generate
      if (GCALL_ACK_EN) begin : g_gcall
         assign gcall_hit = (addr_byte[7:1] == GCALL_ADDR) && !addr_byte[0];
      end else begin : g_no_gcall
         assign gcall_hit = 1'b0;
      end
      if (ALERT_ACK_EN) begin : g_alert
         assign alert_hit = (addr_byte[7:1] == ALERT_ADDR);
      end else begin : g_no_alert
         assign alert_hit = 1'b0;
      end
   endgenerate

   always_comb begin
      if (own_hit)        hit = HIT_OWN;
      else if (gcall_hit) hit = HIT_GCALL;
      else if (alert_hit) hit = HIT_ALERT;
      else                hit = HIT_NONE;
   end
endmodule

// File: rtl/smb_slave_engine.sv
module smb_slave_engine
   import smb_slv_pkg::*;
#(
   parameter logic [6:0] OWN_ADDR     = 7'h2D,
   parameter int         SYNC_STAGES  = 2,
   parameter bit         GCALL_ACK_EN = 1'b1,
   parameter bit         ALERT_ACK_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              timeout_i,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              scl_low_o,
   output logic              sda_low_o,
   output logic [1:0]        match_kind_o,
   output logic              rx_valid_o,
   output logic [BYTE_W-1:0] rx_data_o,
   input  logic              rx_ready_i,
   input  logic              rx_ack_i,
   output logic              tx_req_o,
   input  logic              tx_valid_i,
   input  logic [BYTE_W-1:0] tx_data_i
);
   localparam int CNT_W = $clog2(BYTE_W + 1);
   localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(BYTE_W - 1);
   localparam logic [CNT_W-1:0] FULL_BYTE = CNT_W'(BYTE_W);

   generate
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
      if (OWN_ADDR <= 7'h07 || OWN_ADDR >= 7'h78) begin : g_bad_addr
         $error("OWN_ADDR lies in a reserved address range");
      end
   endgenerate

   logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
   smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det)
   );

   smb_state_e        state_q;
   logic [BYTE_W-1:0] shreg_q;
   logic [CNT_W-1:0]  bitcnt_q;
   logic              rw_q, ack_q, mack_q, scl_low_q;
   logic [1:0]        hit_q, addr_hit;

   smb_addr_match #(
      .OWN_ADDR(OWN_ADDR), .GCALL_ACK_EN(GCALL_ACK_EN), .ALERT_ACK_EN(ALERT_ACK_EN)
   ) u_match (
      .addr_byte(shreg_q), .hit(addr_hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= S_IDLE;
         shreg_q   <= '0;
         bitcnt_q  <= '0;
         rw_q      <= 1'b0;
         ack_q     <= 1'b0;
         mack_q    <= 1'b0;
         hit_q     <= HIT_NONE;
         scl_low_q <= 1'b0;
      end else if (timeout_i) begin
         state_q   <= S_IDLE;
         hit_q     <= HIT_NONE;
         scl_low_q <= 1'b0;
      end else begin
         scl_low_q <= (state_q == S_RHOLD) || (state_q == S_THOLD);
         if (start_det) begin
            state_q  <= S_ADDR;
            bitcnt_q <= '0;
            hit_q    <= HIT_NONE;
         end else if (stop_det) begin
            state_q <= S_IDLE;
            hit_q   <= HIT_NONE;
         end else begin
            unique case (state_q)
               S_ADDR, S_RX: begin
                  if (scl_rise && bitcnt_q < FULL_BYTE) begin
                     shreg_q  <= {shreg_q[BYTE_W-2:0], sda_s};
                     bitcnt_q <= bitcnt_q + 1'b1;
                  end else if (scl_fall && bitcnt_q == FULL_BYTE) begin
                     if (state_q == S_RX) begin
                        state_q <= S_RHOLD;
                     end else if (addr_hit != HIT_NONE) begin
                        state_q <= S_AACK;
                        hit_q   <= addr_hit;
                        rw_q    <= shreg_q[0];
                     end else begin
                        state_q <= S_SKIP;
                     end
                  end
               end
               S_AACK: if (scl_fall) begin
                  state_q  <= rw_q ? S_THOLD : S_RX;
                  bitcnt_q <= '0;
               end
               S_RHOLD: if (rx_ready_i) begin
                  ack_q   <= rx_ack_i;
                  state_q <= S_RACK;
               end
               S_RACK: if (scl_fall) begin
                  state_q  <= S_RX;
                  bitcnt_q <= '0;
               end
               S_THOLD: if (tx_valid_i) begin
                  shreg_q  <= tx_data_i;
                  bitcnt_q <= '0;
                  state_q  <= S_TX;
               end
               S_TX: if (scl_fall) begin
                  if (bitcnt_q == LAST_BIT) begin
                     state_q <= S_TMACK;
                  end else begin
                     shreg_q  <= {shreg_q[BYTE_W-2:0], 1'b0};
                     bitcnt_q <= bitcnt_q + 1'b1;
                  end
               end
               S_TMACK: begin
                  if (scl_rise) mack_q <= ~sda_s;
                  else if (scl_fall) state_q <= mack_q ? S_THOLD : S_SKIP;
               end
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      unique case (state_q)
         S_AACK:  sda_low_o = 1'b1;
         S_RACK:  sda_low_o = ack_q;
         S_TX:    sda_low_o = ~shreg_q[BYTE_W-1];
         default: sda_low_o = 1'b0;
      endcase
   end

   assign scl_low_o    = scl_low_q;
   assign rx_valid_o   = (state_q == S_RHOLD);
   assign rx_data_o    = shreg_q;
   assign tx_req_o     = (state_q == S_THOLD);
   assign match_kind_o = hit_q;
endmodule

// File: rtl/smb_slave_engine_chk.sv
module smb_slave_engine_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       timeout_i,
   input logic       scl_s,
   input logic       scl_low_o,
   input logic       sda_low_o,
   input logic       rx_valid_o,
   input logic [7:0] rx_data_o,
   input logic       rx_ready_i,
   input logic       tx_req_o,
   input logic       tx_valid_i
);
   p_idle_after_timeout_r11: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_i |=> (!scl_low_o && !sda_low_o && !rx_valid_o && !tx_req_o));

   p_rx_byte_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid_o && !rx_ready_i && !timeout_i) |=> (rx_valid_o && $stable(rx_data_o)));

   p_handshake_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(rx_valid_o && tx_req_o));

   p_stretch_while_waiting_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((rx_valid_o || tx_req_o) && $past(rx_valid_o || tx_req_o)) |-> scl_low_o);

   p_tx_req_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_req_o && !tx_valid_i && !timeout_i) |=> tx_req_o);

   p_sda_moves_in_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(timeout_i) && $changed(sda_low_o)) |-> !scl_s);
endmodule

bind smb_slave_engine smb_slave_engine_chk u_chk (
   .clk(clk), .rst_n(rst_n), .timeout_i(timeout_i), .scl_s(scl_s),
   .scl_low_o(scl_low_o), .sda_low_o(sda_low_o), .rx_valid_o(rx_valid_o),
   .rx_data_o(rx_data_o), .rx_ready_i(rx_ready_i), .tx_req_o(tx_req_o),
   .tx_valid_i(tx_valid_i)
);

// File: tb/smb_slave_engine_test.sv
module smb_slave_engine_test;
   localparam logic [6:0] OWN = 7'h2D;
   localparam int Q = 5;
   localparam int RSP_DELAY = 24;

   logic clk = 1'b0, rst_n = 1'b0, timeout_i = 1'b0;
   logic scl_m = 1'b1, sda_m = 1'b1;
   logic scl_low_o, sda_low_o, rx_valid_o, tx_req_o;
   logic [1:0] match_kind_o;
   logic [7:0] rx_data_o;
   logic rx_ready_i = 1'b0, rx_ack_i = 1'b0, tx_valid_i = 1'b0;
   logic [7:0] tx_data_i = 8'h00;
   logic n_scl_low, n_sda_low, n_rx_valid, n_tx_req;
   logic [1:0] n_kind;
   logic [7:0] n_rx_data;
   wire scl_line = scl_m & ~scl_low_o;
   wire sda_line = sda_m & ~sda_low_o;

   int n_chk = 0, n_fail = 0;
   int rx_n = 0, tx_n = 0, exp_tx = 0;
   logic [7:0] rx_log [0:15];
   bit resp_en = 1'b1;
   bit noopt_ack;

   always #4 clk = ~clk;

   smb_slave_engine #(.OWN_ADDR(OWN), .SYNC_STAGES(2), .GCALL_ACK_EN(1'b1), .ALERT_ACK_EN(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .timeout_i(timeout_i), .scl_i(scl_line), .sda_i(sda_line),
      .scl_low_o(scl_low_o), .sda_low_o(sda_low_o), .match_kind_o(match_kind_o),
      .rx_valid_o(rx_valid_o), .rx_data_o(rx_data_o), .rx_ready_i(rx_ready_i), .rx_ack_i(rx_ack_i),
      .tx_req_o(tx_req_o), .tx_valid_i(tx_valid_i), .tx_data_i(tx_data_i));

   smb_slave_engine #(.OWN_ADDR(OWN), .SYNC_STAGES(2), .GCALL_ACK_EN(1'b0), .ALERT_ACK_EN(1'b0)) uut_noopt (
      .clk(clk), .rst_n(rst_n), .timeout_i(timeout_i), .scl_i(scl_line), .sda_i(sda_line),
      .scl_low_o(n_scl_low), .sda_low_o(n_sda_low), .match_kind_o(n_kind),
      .rx_valid_o(n_rx_valid), .rx_data_o(n_rx_data), .rx_ready_i(1'b1), .rx_ack_i(1'b0),
      .tx_req_o(n_tx_req), .tx_valid_i(1'b1), .tx_data_i(8'h00));

   function automatic logic [7:0] tx_pat(input int k);
      return 8'hC3 ^ 8'(k * 37);
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // local responder
   initial begin
      int wait_cnt = 0;
      forever begin
         @(negedge clk);
         rx_ready_i = 1'b0;
         tx_valid_i = 1'b0;
         if (resp_en && (rx_valid_o || tx_req_o)) begin
            wait_cnt++;
            if (wait_cnt == RSP_DELAY) begin
               wait_cnt = 0;
               if (rx_valid_o) begin
                  rx_log[rx_n[3:0]] = rx_data_o;
                  rx_n++;
                  rx_ready_i = 1'b1;
                  rx_ack_i = (rx_data_o != 8'hFF);
               end else begin
                  tx_data_i = tx_pat(tx_n);
                  tx_n++;
                  tx_valid_i = 1'b1;
               end
            end
         end else begin
            wait_cnt = 0;
         end
      end
   end

   task automatic wq();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bit_xfer(input bit b, output bit s, output int stretch);
      sda_m = b; wq();
      scl_m = 1'b1; stretch = 0;
      @(negedge clk);
      while (!scl_line) begin stretch++; @(negedge clk); end
      wq();
      s = sda_line; noopt_ack = n_sda_low;
      wq();
      scl_m = 1'b0; wq();
   endtask

   task automatic bus_start();
      sda_m = 1'b1; wq();
      scl_m = 1'b1; @(negedge clk);
      while (!scl_line) @(negedge clk);
      wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; wq();
      scl_m = 1'b1; @(negedge clk);
      while (!scl_line) @(negedge clk);
      wq(); sda_m = 1'b1; wq(); wq();
   endtask

   task automatic byte_write(input logic [7:0] d, output bit ack, output int st);
      bit s; int t;
      for (int i = 7; i >= 0; i--) bit_xfer(d[i], s, t);
      bit_xfer(1'b1, s, st);
      ack = !s;
   endtask

   task automatic byte_read(input bit mack, output logic [7:0] d, output int st);
      bit s; int t;
      for (int i = 7; i >= 0; i--) begin
         bit_xfer(1'b1, s, t);
         if (i == 7) st = t;
         d[i] = s;
      end
      bit_xfer(!mack, s, t);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      bit ack; int st; logic [7:0] d; int base;
      logic [7:0] wr [0:3];
      wr[0] = 8'h5A; wr[1] = 8'hFF; wr[2] = 8'h00; wr[3] = 8'hA5;
      repeat (5) @(negedge clk);
      check(!scl_low_o && !sda_low_o && !rx_valid_o && !tx_req_o, "R1 reset state",
            {scl_low_o, sda_low_o, rx_valid_o, tx_req_o}, 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      check(!scl_low_o && !sda_low_o, "R1 lines released after reset", {scl_low_o, sda_low_o}, 0);

      // R2 R3 R4: sweep of every address byte
      for (int a = 0; a < 128; a++) begin
         for (int rw = 0; rw < 2; rw++) begin
            bit exp_ack; bit exp_n; int exp_kind;
            exp_kind = (a == OWN) ? 1 : (a == 0 && rw == 0) ? 2 : (a == 12) ? 3 : 0;
            exp_ack = (exp_kind != 0);
            exp_n = (a == OWN);
            bus_start();
            byte_write(8'((a << 1) | rw), ack, st);
            check(ack == exp_ack, "R2/R3/R4 address ack", ack, exp_ack);
            check(noopt_ack == exp_n, "R4 ack with options off", noopt_ack, exp_n);
            if (exp_ack) begin
               check(match_kind_o == 2'(exp_kind), "R3 match kind", match_kind_o, exp_kind);
               if (rw == 1) begin
                  byte_read(1'b0, d, st);
                  check(d == tx_pat(exp_tx), "R7 alert/own read data", d, tx_pat(exp_tx));
                  exp_tx++;
               end
            end
            bus_stop();
         end
      end

      // R2: unmatched address, following byte not delivered
      base = rx_n;
      bus_start();
      byte_write({7'h2B, 1'b0}, ack, st);
      check(!ack, "R2 foreign address not acked", ack, 0);
      byte_write(8'h33, ack, st);
      check(!ack && rx_n == base, "R2 byte after foreign address ignored", rx_n - base, 0);
      bus_stop();

      // R5 R6: write transaction
      base = rx_n;
      bus_start();
      byte_write({OWN, 1'b0}, ack, st);
      check(ack, "R2 own write address acked", ack, 1);
      for (int k = 0; k < 4; k++) begin
         byte_write(wr[k], ack, st);
         check(ack == (wr[k] != 8'hFF), "R6 data ack choice", ack, wr[k] != 8'hFF);
         check(rx_n == base + k + 1 && rx_log[4'(base + k)] == wr[k], "R5 received byte",
               rx_log[4'(base + k)], wr[k]);
         check(st >= 8, "R5 clock stretched per byte", st, 8);
      end
      bus_stop();

      // R7 R8: read transaction
      bus_start();
      byte_write({OWN, 1'b1}, ack, st);
      check(ack && match_kind_o == 2'd1, "R2 own read address acked", {ack, match_kind_o}, 3'b101);
      for (int k = 0; k < 3; k++) begin
         byte_read(k != 2, d, st);
         check(d == tx_pat(exp_tx), "R7 read byte", d, tx_pat(exp_tx));
         check(st >= 8, "R7 stretched for tx byte", st, 8);
         exp_tx++;
      end
      byte_read(1'b0, d, st);
      check(d == 8'hFF, "R8 line released after master NACK", d, 8'hFF);
      check(tx_n == exp_tx && !tx_req_o, "R8 no request after NACK", tx_n, exp_tx);
      bus_stop();

      // R9: repeated START mid-address, then write, then read
      base = rx_n;
      bus_start();
      for (int i = 7; i >= 4; i--) begin bit s; int t; bit_xfer(OWN[i-1], s, t); end
      bus_start();
      byte_write({OWN, 1'b0}, ack, st);
      check(ack, "R9 address after mid-byte START acked", ack, 1);
      byte_write(8'h11, ack, st);
      check(ack && rx_log[4'(base)] == 8'h11, "R9 data after restart", rx_log[4'(base)], 8'h11);
      bus_start();
      byte_write({OWN, 1'b1}, ack, st);
      check(ack, "R9 repeated START read address acked", ack, 1);
      byte_read(1'b0, d, st);
      check(d == tx_pat(exp_tx), "R9 read after repeated START", d, tx_pat(exp_tx));
      exp_tx++;
      bus_stop();

      // R10: bytes after STOP without START
      base = rx_n;
      scl_m = 1'b0; wq();
      byte_write({OWN, 1'b0}, ack, st);
      check(!ack, "R10 no ack without START", ack, 0);
      byte_write(8'h44, ack, st);
      check(!ack && rx_n == base, "R10 no delivery without START", rx_n - base, 0);
      bus_stop();

      // R11: timeout while stretching
      resp_en = 1'b0;
      bus_start();
      byte_write({OWN, 1'b1}, ack, st);
      repeat (10) @(negedge clk);
      check(scl_low_o && tx_req_o, "R7 holds clock waiting for byte", {scl_low_o, tx_req_o}, 3);
      timeout_i = 1'b1;
      @(negedge clk);
      timeout_i = 1'b0;
      check(!scl_low_o && !sda_low_o && !tx_req_o && match_kind_o == 2'd0, "R11 released by timeout",
            {scl_low_o, sda_low_o, tx_req_o}, 0);
      resp_en = 1'b1;
      bus_stop();
      base = rx_n;
      bus_start();
      byte_write({OWN, 1'b0}, ack, st);
      byte_write(8'h77, ack, st);
      check(ack && rx_log[4'(base)] == 8'h77, "R11 recovers after timeout", rx_log[4'(base)], 8'h77);
      bus_stop();

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule